// File: doc/BRIEF.md
# Line-Buffered Bayer-to-RGB Converter

This block sits between a camera's parallel raw-pixel port and a display pipeline that shows a 640x480 picture at the same frame rate as the sensor, but on its own pixel clock. The camera supplies 10-bit raw colour-filter samples with a pixel clock, a line-valid strobe and a frame strobe. The display side supplies only its clock and an active-pixel enable. The block returns one 24-bit RGB pixel per enabled display cycle.

Three line memories rotate. The camera writes the incoming line into one of them while the display reads the two most recently completed lines together and forms colour from a 2x2 window. Because both sides run at the same line rate, these memories also absorb the frequency and phase difference between the two clocks, so no frame store is needed. A counter of completed lines crosses into the display domain in Gray code, and that counter tells the display which pair of memories is safe to read.

Top module: `bayer_line_demosaic`

## Requirements
- R1: Input bits 13..10 of `cam_data` are reserved. They have no effect on any output; only bits 9..0 are stored.
- R2: While `cam_hs` is high, each camera clock stores one sample at the next column, starting at column 0. A falling edge of `cam_hs` completes the line. Line memories are filled in rotation 0,1,2,0,... The display reads the newest completed line as the lower row of the window and the line before it as the upper row.
- R3: A rising edge of `cam_vs` restarts the row index and the column at 0. The first display line after a new frame's first camera line is black.
- R4: Output is black (all channels zero, `out_valid` still high) until two lines of the current frame have been completed. This includes the time after reset before any line arrives.
- R5: `out_valid` equals `disp_de` delayed by one display clock. While `out_valid` is low, all three channels are zero.
- R6: Output pixel at display column c uses raw columns 2*floor(c/2) and 2*floor(c/2)+1 of the two rows. Red and blue are the single red and blue samples in that window. Green is floor((g1+g2)/2) of the two green samples.
- R7: Parameter `PHASE` places red at row parity PHASE[1] and column parity PHASE[0], and blue at the opposite parities. Row parity counts from 0 at the frame start, and the upper window row is the older line.
- R8: Each output channel is bits 9..2 of the 10-bit colour value.
- R9: The completed-line count crosses to the display clock as a Gray code that changes at most one bit per camera clock. The line pair is taken in the last display cycle before `disp_de` rises and is held for the whole display line.
- R10: Correct pixels result with camera and display clocks of unrelated period and phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cam_clk | input | 1 | Camera pixel clock |
| cam_rst_n | input | 1 | Active-low reset, camera domain |
| cam_vs | input | 1 | Frame strobe; rising edge starts a frame |
| cam_hs | input | 1 | Line valid; high while samples arrive |
| cam_data | input | 14 | Raw sample in bits 9..0; bits 13..10 reserved |
| disp_clk | input | 1 | Display pixel clock |
| disp_rst_n | input | 1 | Active-low reset, display domain |
| disp_de | input | 1 | Display active-pixel enable |
| out_valid | output | 1 | Pixel on the colour outputs is valid |
| out_r | output | 8 | Red channel |
| out_g | output | 8 | Green channel |
| out_b | output | 8 | Blue channel |

## Verification
The assertions assume that the display starts reading a line only after the camera has completed it and the Gray count has settled. They also assume that the display finishes that line before the camera completes two further lines, that `disp_de` drops for at least one cycle between lines, and that `cam_vs` does not rise while `cam_hs` is high. The stimulus meets these rules by running whole camera lines and whole display lines one after another, with idle gaps of several cycles on each clock. The two clocks have unrelated periods. Reserved input bits carry changing junk throughout.

// File: rtl/bayer_line_demosaic.sv
module bayer_line_demosaic #(
  parameter int IN_W        = 14,
  parameter int RAW_W       = 10,
  parameter int OUT_W       = 8,
  parameter int LINE_PIX    = 640,
  parameter int FRAME_LINES = 480,
  parameter int PHASE       = 0,
  parameter int CNT_W       = 4
) (
  input  logic             cam_clk,
  input  logic             cam_rst_n,
  input  logic             cam_vs,
  input  logic             cam_hs,
  input  logic [IN_W-1:0]  cam_data,
  input  logic             disp_clk,
  input  logic             disp_rst_n,
  input  logic             disp_de,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_r,
  output logic [OUT_W-1:0] out_g,
  output logic [OUT_W-1:0] out_b
);
  localparam int COL_W = $clog2(LINE_PIX);
  localparam int ROW_W = $clog2(FRAME_LINES);
  localparam int NBANK = 3;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_PIX - 1);
  localparam bit RED_Y = ((PHASE >> 1) & 1) == 1;
  localparam bit RED_X = (PHASE & 1) == 1;

  logic [RAW_W-1:0] line_mem [NBANK][LINE_PIX];
  logic [ROW_W-1:0] row_tag  [NBANK];

  // ---------------- camera domain ----------------
  logic             vs_d, hs_d;
  logic [COL_W-1:0] wr_col;
  logic [ROW_W-1:0] wr_row;
  logic [1:0]       wr_bank;
  logic [CNT_W-1:0] done_bin, done_gray, done_next;
  logic             line_end, frame_start;

  assign line_end    = hs_d & ~cam_hs;
  assign frame_start = cam_vs & ~vs_d;
  assign done_next   = done_bin + 1'b1;

  always_ff @(posedge cam_clk)
    if (cam_hs) line_mem[wr_bank][wr_col] <= cam_data[RAW_W-1:0];

  always_ff @(posedge cam_clk or negedge cam_rst_n)
    if (!cam_rst_n) begin
      vs_d      <= 1'b0;
      hs_d      <= 1'b0;
      wr_col    <= '0;
      wr_row    <= '0;
      wr_bank   <= 2'd0;
      done_bin  <= '0;
      done_gray <= '0;
      for (int i = 0; i < NBANK; i++) row_tag[i] <= '0;
    end else begin
      vs_d <= cam_vs;
      hs_d <= cam_hs;
      if (frame_start) begin
        wr_row <= '0;
        wr_col <= '0;
      end else if (line_end) begin
        row_tag[wr_bank] <= wr_row;
        wr_row    <= wr_row + 1'b1;
        wr_col    <= '0;
        wr_bank   <= (wr_bank == 2'd2) ? 2'd0 : wr_bank + 2'd1;
        done_bin  <= done_next;
        done_gray <= done_next ^ (done_next >> 1);
      end else if (cam_hs && wr_col != LAST_COL) begin
        wr_col <= wr_col + 1'b1;
      end
    end

  // R9
  gray_step_chk: assert property (@(posedge cam_clk) disable iff (!cam_rst_n)
    $countones(done_gray ^ $past(done_gray)) <= 1);
  // R2
  wr_col_range_chk: assert property (@(posedge cam_clk) disable iff (!cam_rst_n)
    wr_col <= LAST_COL && wr_bank < 2'd3);
  // R2
  bank_rotate_chk: assert property (@(posedge cam_clk) disable iff (!cam_rst_n)
    (line_end && !frame_start) |=> wr_bank != $past(wr_bank));

  // ---------------- display domain ----------------
  logic [CNT_W-1:0] sync1, sync2, sync_bin, seen_bin;
  logic [1:0]       disp_new, live_old, lat_new, lat_old;
  logic             have_line, live_ok, lat_ok, lat_par;
  logic [ROW_W-1:0] live_row;
  logic [COL_W-1:0] rd_col, col_e, col_o;

  always_comb begin
    sync_bin[CNT_W-1] = sync2[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) sync_bin[i] = sync_bin[i+1] ^ sync2[i];
  end

  assign live_old = (disp_new == 2'd0) ? 2'd2 : disp_new - 2'd1;
  assign live_row = row_tag[disp_new];
  assign live_ok  = have_line && (live_row != '0);

  always_ff @(posedge disp_clk or negedge disp_rst_n)
    if (!disp_rst_n) begin
      sync1     <= '0;
      sync2     <= '0;
      seen_bin  <= '0;
      disp_new  <= 2'd2;
      have_line <= 1'b0;
      lat_new   <= 2'd2;
      lat_old   <= 2'd1;
      lat_ok    <= 1'b0;
      lat_par   <= 1'b0;
      rd_col    <= '0;
    end else begin
      sync1 <= done_gray;
      sync2 <= sync1;
      if (sync_bin != seen_bin) begin
        seen_bin  <= seen_bin + 1'b1;
        disp_new  <= (disp_new == 2'd2) ? 2'd0 : disp_new + 2'd1;
        have_line <= 1'b1;
      end
      if (!disp_de) begin
        lat_new <= disp_new;
        lat_old <= live_old;
        lat_ok  <= live_ok;
        lat_par <= ~live_row[0];
      end
      rd_col <= !disp_de ? '0 : (rd_col == LAST_COL) ? rd_col : rd_col + 1'b1;
    end

  // R9
  pair_hold_chk: assert property (@(posedge disp_clk) disable iff (!disp_rst_n)
    ($past(disp_de) && disp_de) |-> $stable(lat_new) && $stable(lat_ok));

  // ---------------- demosaic ----------------
  logic [RAW_W-1:0] t0, t1, b0, b1, t_r, t_o, b_r, b_o, rv, bv, gv;
  logic [RAW_W:0]   gsum;
  logic             red_top;

  assign col_e   = {rd_col[COL_W-1:1], 1'b0};
  assign col_o   = {rd_col[COL_W-1:1], 1'b1};
  assign t0      = line_mem[lat_old][col_e];
  assign t1      = line_mem[lat_old][col_o];
  assign b0      = line_mem[lat_new][col_e];
  assign b1      = line_mem[lat_new][col_o];
  assign t_r     = RED_X ? t1 : t0;
  assign t_o     = RED_X ? t0 : t1;
  assign b_r     = RED_X ? b1 : b0;
  assign b_o     = RED_X ? b0 : b1;
  assign red_top = (lat_par == RED_Y);
  assign rv      = red_top ? t_r : b_r;
  assign bv      = red_top ? b_o : t_o;
  assign gsum    = {1'b0, red_top ? t_o : b_o} + {1'b0, red_top ? b_r : t_r};
  assign gv      = gsum[RAW_W:1];

  always_ff @(posedge disp_clk or negedge disp_rst_n)
    if (!disp_rst_n) begin
      out_valid <= 1'b0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= disp_de;
      out_r     <= (disp_de && lat_ok) ? rv[RAW_W-1 -: OUT_W] : '0;
      out_g     <= (disp_de && lat_ok) ? gv[RAW_W-1 -: OUT_W] : '0;
      out_b     <= (disp_de && lat_ok) ? bv[RAW_W-1 -: OUT_W] : '0;
    end

  // R5
  idle_black_chk: assert property (@(posedge disp_clk) disable iff (!disp_rst_n)
    !out_valid |-> (out_r == '0 && out_g == '0 && out_b == '0));
  // R5
  valid_follow_chk: assert property (@(posedge disp_clk) disable iff (!disp_rst_n)
    $past(disp_de) |-> out_valid);
endmodule

// File: tb/test_bayer_line_demosaic.sv
module test_bayer_line_demosaic;
  localparam int DISP_PERIOD = 10;
  localparam int CAM_PERIOD  = 7;
  localparam int LP = 64;
  localparam int FL = 16;
  localparam int NV = 6;
  // each vector: {seed[9:0], reserved junk[3:0]} for one camera row
  localparam logic [13:0] VEC [NV] = '{
    {10'd0, 4'hF}, {10'd311, 4'h5}, {10'd77, 4'hA},
    {10'd1000, 4'h3}, {10'd512, 4'hC}, {10'd255, 4'h9}};

  logic cam_clk = 0, disp_clk = 0;
  logic cam_rst_n = 0, disp_rst_n = 0;
  logic cam_vs = 0, cam_hs = 0, disp_de = 0;
  logic [13:0] cam_data = '0;
  logic va, vb;
  logic [7:0] ra, ga, ba, rb, gb, bb;
  int errors = 0, checks = 0;
  int mdl [FL][LP];

  always #(CAM_PERIOD/2.0)  cam_clk  = ~cam_clk;
  always #(DISP_PERIOD/2.0) disp_clk = ~disp_clk;

  bayer_line_demosaic #(.LINE_PIX(LP), .FRAME_LINES(FL), .PHASE(0)) i_bayer_line_demosaic (
    .cam_clk, .cam_rst_n, .cam_vs, .cam_hs, .cam_data, .disp_clk, .disp_rst_n, .disp_de,
    .out_valid(va), .out_r(ra), .out_g(ga), .out_b(ba));
  bayer_line_demosaic #(.LINE_PIX(LP), .FRAME_LINES(FL), .PHASE(3)) i_bayer_line_demosaic_p3 (
    .cam_clk, .cam_rst_n, .cam_vs, .cam_hs, .cam_data, .disp_clk, .disp_rst_n, .disp_de,
    .out_valid(vb), .out_r(rb), .out_g(gb), .out_b(bb));

  task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_px(int ph, int top, int col);
    int e, rs, bs, gs, v;
    bit yr, xr;
    e = col & ~1; rs = 0; bs = 0; gs = 0;
    for (int y = top; y <= top + 1; y++)
      for (int x = e; x <= e + 1; x++) begin
        v  = mdl[y][x];
        yr = (y % 2) == ((ph >> 1) & 1);
        xr = (x % 2) == (ph & 1);
        if (yr && xr) rs = v;
        else if (!yr && !xr) bs = v;
        else gs += v;
      end
    gs = gs / 2;
    return {8'(rs >> 2), 8'(gs >> 2), 8'(bs >> 2)};
  endfunction

  task automatic frame_pulse();
    @(negedge cam_clk) cam_vs = 1;
    repeat (3) @(negedge cam_clk);
    cam_vs = 0;
    repeat (3) @(negedge cam_clk);
  endtask

  task automatic send_line(input int row, input logic [13:0] v);
    for (int c = 0; c < LP; c++) begin
      @(negedge cam_clk);
      cam_hs = 1;
      mdl[row][c] = (int'(v[13:4]) * 37 + c * 29 + row * 5) & 10'h3FF;
      cam_data = {4'(v[3:0] ^ 4'(c)), 10'(mdl[row][c])};
    end
    @(negedge cam_clk) cam_hs = 0;
    cam_data = 14'h3C00;
    repeat (4) @(negedge cam_clk);
  endtask

  // black = 1: all pixels zero; else window rows top, top+1
  task automatic read_line(input bit black, input int top, input string req);
    repeat (12) @(negedge disp_clk);
    for (int c = 0; c <= LP; c++) begin
      @(negedge disp_clk);
      if (c > 0) begin
        check({req, " p0"}, {va, ra, ga, ba}, {1'b1, black ? 24'd0 : expect_px(0, top, c - 1)});
        check({req, " p3 R7"}, {vb, rb, gb, bb}, {1'b1, black ? 24'd0 : expect_px(3, top, c - 1)});
      end
      disp_de = (c < LP);
    end
    @(negedge disp_clk);
    check("R5 idle after line", {va, ra, ga, ba}, 25'd0);
  endtask

  initial begin
    repeat (200000) @(posedge disp_clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge disp_clk);
    check("R5 reset state", {va, ra, ga, ba}, 25'd0);
    cam_rst_n = 1; disp_rst_n = 1;
    // R4: before any line the output is black
    read_line(1, 0, "R4 no line yet");
    frame_pulse();
    // R1 R2 R6 R8 R9 R10: table walk, junk in reserved bits
    for (int i = 0; i < NV; i++) begin
      send_line(i, VEC[i]);
      if (i == 0) read_line(1, 0, "R4 one line only");
      else        read_line(0, i - 1, "R1 R2 R6 R8 R9 R10 pixel");
    end
    // R3: new frame restarts row parity, first line black
    frame_pulse();
    send_line(0, {10'd901, 4'hF});
    read_line(1, 0, "R3 first line of frame");
    send_line(1, {10'd13, 4'h0});
    read_line(0, 0, "R3 R7 row parity restart");
    send_line(2, {10'd640, 4'h6});
    read_line(0, 1, "R2 rotation after frame");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule